// File: doc/BRIEF.md
# Four-Channel 8-bit PWM DAC

This block produces four independent pulse-width-modulated outputs for low-rate digital-to-analog conversion. Each channel drives an open-drain pin through a pull-down enable. When the enable is 0 the transistor is off and an external pull-up holds the pin high. All four channels share one 8-bit period counter. The counter advances only on cycles where the `tick` clock enable is high, so one period lasts 256 ticks. With a tick rate of 2.25 MHz the period is about 114 µs, which is about 8.79 kHz.

Software loads a duty value into the holding register of the selected channel. Each channel keeps its holding register separate from its active compare register. The holding value moves into the compare register only at the period boundary. Each pin has a mode bit. When the bit is 0 the pin is a plain output driven from a level input. When the bit is 1 the pin follows the PWM compare. Raising the stop input or asserting reset releases every pull-down, and stop also freezes the period counter.

Top module: `pwm_dac_quad`

## Requirements
- R1: While `rst_n` is low, every bit of `pull_dn` is 0. Reset clears the counter, all holding registers and all compare registers. As a result, a PWM-mode channel pulls down for the whole first period after reset.
- R2: The period counter advances by one only in a cycle where `tick` is 1 and `stop` is 0. It wraps from 255 to 0, so a period is 256 ticks.
- R3: A write sets the holding register of channel `wr_sel` (0 to 3) to `wr_data`. The compare register in use stays unchanged until the next wrap.
- R4: On a tick that moves the counter from 255 to 0, every compare register takes the value that its holding register had before that edge.
- R5: In PWM mode (`mode[i]`=1), `pull_dn[i]` is 1 exactly while the counter is at or above the active compare value of channel i.
- R6: An active value of 0 pulls the pin down for all 256 counts. An active value of 255 releases the pin for counts 0 to 254 and pulls it down only at count 255.
- R7: In output mode (`mode[i]`=0), `pull_dn[i]` equals the inverse of `gpo[i]`, so `gpo[i]`=1 reads high on the pin.
- R8: While `stop` is 1, every bit of `pull_dn` is 0 and the counter and compare registers hold. After `stop` falls, PWM resumes from the frozen count.
- R9: Switching `mode[i]` from 0 to 1 applies the current count and active compare value in the same cycle, without waiting for a period boundary.
- R10: A write to one channel leaves the holding and compare values of the other three channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for the period counter |
| stop | input | 1 | Clock stop: releases all pins and freezes the counter |
| wr_en | input | 1 | Write strobe for a duty value |
| wr_sel | input | 2 | Channel selected by the write |
| wr_data | input | 8 | Duty value to load |
| mode | input | 4 | Per-pin mode: 1 = PWM, 0 = plain output |
| gpo | input | 4 | Pin level used in plain output mode |
| pull_dn | output | 4 | Pull-down enable for each pin: 1 = pin low |

## Verification
A corrupted counter or compare register shows at the pins within one period. The low-going edge of some PWM output moves to the wrong count, and a cycle-level model of the counter catches this on the first bad cycle. A compare register loaded at the wrong moment shows up as an edge position that changes in mid-period instead of at the wrap. Sweeping duty values over all 256 codes on four channels at once exposes any compare that is off by one, as well as the saturation codes 0 and 255.

// File: rtl/pwm_dac_quad.sv
module pwm_dac_quad #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   stop,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_sel,
  input  logic [DW-1:0]          wr_data,
  input  logic [NCH-1:0]         mode,
  input  logic [NCH-1:0]         gpo,
  output logic [NCH-1:0]         pull_dn
);
  localparam logic [DW-1:0] CNT_MAX = {DW{1'b1}};

  logic [DW-1:0]           cnt_q;
  logic [NCH-1:0][DW-1:0]  hold_q;
  logic [NCH-1:0][DW-1:0]  act_q;
  logic                    step, wrap;

  assign step = tick && !stop;
  assign wrap = step && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (step) cnt_q <= cnt_q + 1'b1;
      if (wrap) act_q <= hold_q;
      if (wr_en) hold_q[wr_sel] <= wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n || stop) pull_dn[i] = 1'b0;
      else if (mode[i])   pull_dn[i] = (cnt_q >= act_q[i]);
      else                pull_dn[i] = !gpo[i];
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R8
  AST_ACT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q)); // R3
  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> act_q == $past(hold_q)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> pull_dn == '0); // R8
endmodule

// File: tb/test_pwm_dac_quad.sv
`timescale 1ns/1ps
module test_pwm_dac_quad;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0, stop = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] mode = 4'hF, gpo = 4'h0;
  logic [3:0] pull_dn;

  pwm_dac_quad i_pwm_dac_quad (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stop(stop), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .mode(mode), .gpo(gpo), .pull_dn(pull_dn)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int m_cnt = 0;
  logic [7:0] m_hold [4];
  logic [7:0] m_act [4];
  string phase = "";
  bit done = 0;

  function automatic string tag_for(int i);
    if (phase != "") return phase;
    if (stop) return "R8";
    if (!mode[i]) return "R7";
    if (m_act[i] == 8'd0 || m_act[i] == 8'd255) return "R6";
    if (m_hold[i] != m_act[i]) return "R3";
    if (m_cnt == 0) return "R4";
    return "R5";
  endfunction

  task automatic check_pins();
    for (int i = 0; i < 4; i++) begin
      logic e;
      if (!rst_n || stop) e = 1'b0;
      else if (!mode[i]) e = !gpo[i];
      else e = (m_cnt >= int'(m_act[i]));
      checks++;
      if (pull_dn[i] !== e) begin
        failures++;
        $display("FAIL %s ch%0d pull_dn=%b expected=%b cnt=%0d", tag_for(i), i, pull_dn[i], e, m_cnt);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (!rst_n) begin
      m_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_hold[i] = 0; m_act[i] = 0; end
    end else begin
      if (tick && !stop) begin
        if (m_cnt == 255) begin
          m_cnt = 0;
          for (int i = 0; i < 4; i++) m_act[i] = m_hold[i];
        end else m_cnt++;
      end
      if (wr_en) m_hold[wr_sel] = wr_data;
    end
    #1 check_pins();
    @(negedge clk);
  endtask

  task automatic write_ch(int ch, logic [7:0] v);
    wr_en = 1; wr_sel = ch[1:0]; wr_data = v;
    cyc();
    wr_en = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_hold[i] = 0; m_act[i] = 0; end
    @(negedge clk);
    // R1: pins released during reset even with PWM mode and gpo low
    phase = "R1";
    tick = 1;
    for (int k = 0; k < 5; k++) cyc();
    rst_n = 1;
    for (int k = 0; k < 20; k++) cyc();
    phase = "";
    // main sweep: R3 R4 R5 R6 with all 256 codes on every channel
    for (int p = 0; p < 256; p++) begin
      while (m_cnt != 10) cyc();
      write_ch(0, p[7:0]);
      write_ch(1, 8'(255 - p));
      write_ch(2, p[7:0] ^ 8'hA5);
      write_ch(3, 8'(p * 7));
    end
    while (m_cnt != 255) cyc();
    // R2: counter advances only on ticks
    phase = "R2";
    for (int k = 0; k < 700; k++) begin
      tick = k[0];
      cyc();
    end
    tick = 1;
    // R7: plain output mode on channels 0 and 2
    phase = "";
    mode = 4'b1010;
    for (int g = 0; g < 16; g++) begin
      gpo = g[3:0];
      for (int k = 0; k < 5; k++) cyc();
    end
    // R9: switch to PWM mid-period
    mode = 4'h0;
    write_ch(0, 8'd40); write_ch(1, 8'd90); write_ch(2, 8'd160); write_ch(3, 8'd220);
    while (m_cnt != 100) cyc();
    phase = "R9";
    mode = 4'hF;
    for (int k = 0; k < 160; k++) cyc();
    // R8: stop releases pins and freezes counter
    phase = "";
    stop = 1;
    for (int k = 0; k < 300; k++) cyc();
    stop = 0;
    phase = "R8";
    for (int k = 0; k < 300; k++) cyc();
    // R10: writing one channel leaves the others alone
    phase = "R10";
    write_ch(2, 8'd3);
    for (int k = 0; k < 600; k++) cyc();
    phase = "";
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule